// File: doc/BRIEF.md
# Image Sensor Frame Readout Sequencer

This block paces pixel readout across a rectangular viewing window of a sensor array. While a capture runs it emits one pixel slot per clock, left to right inside a row and top to bottom down the window, and reports the row and column of each slot next to a pixel-valid strobe. Three active-low status lines mark the last pixel of a row, the last pixel of a frame, and the completion of a capture. The host sees a run flag that stays high while a capture is active.

A run input starts and stops capture. A mode input picks between one frame per run request and back-to-back frames. In back-to-back mode the frame period is never shorter than a programmed integration time: when integration is longer than the window's pixel count, idle cycles are inserted before the next frame. When run is withdrawn, a policy input chooses between finishing the current frame and cutting it short with all three status lines pulsed together. The window bounds and the integration time are taken at the start of each frame.

Top module: `frame_readout_seq`

## Requirements
- R1: While reading, the block shows one pixel per cycle with `pix_valid` high, from (`row_lo`,`col_lo`) to (`row_hi`,`col_hi`), column first, then row; `pix_col`/`pix_row` read 0 when `pix_valid` is low. The window needs the high bound at or above the low bound on both axes.
- R2: `eor_n` is low exactly in the cycle of the last pixel of each window row; `eof_n` is low in the same cycle when that row is the bottom row, and low at no other time except during an abort (R9).
- R3: In idle, a frame starts when `run` is high and was low in the previous cycle; the first pixel appears in the next cycle, and `run_flag` is high from that cycle until the block is idle again.
- R4: With `cont_mode` at 0, the block is idle with `run_flag` low in the cycle after end-of-frame, and starts no new frame while `run` stays high.
- R5: With `cc_enable` at 1, `irq_cc_n` is low together with `eof_n` on the last frame of a capture (the frame whose last pixel sees `cont_mode` and `run` not both high) and during an abort; with `cc_enable` at 0 it stays high.
- R6: With `cont_mode` and `run` high at end-of-frame and the integration time no greater than the window's pixel count, the next frame's first pixel follows in the very next cycle.
- R7: When the integration time exceeds the window's pixel count, exactly (integration time − pixel count) cycles with `pix_valid` low and all status lines high lie between one frame's last pixel and the next frame's first.
- R8: With `stop_at_end` at 1, dropping `run` lets the frame finish normally before the block goes idle; dropping `run` during the inter-frame gap returns the block to idle with no status pulse.
- R9: With `stop_at_end` at 0, a pixel cycle that sees `run` low is followed by one cycle with `pix_valid` low and `eor_n`, `eof_n` (and `irq_cc_n` if enabled) low together, then idle.
- R10: Window bounds and integration time are latched at each frame start; changing them during a frame has no effect on that frame.
- R11: Synchronous reset returns the block to idle: all status lines high, `pix_valid` and `run_flag` low, coordinates 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Capture request level |
| cont_mode | input | 1 | 1: back-to-back frames, 0: one frame per request |
| stop_at_end | input | 1 | 1: finish frame on stop, 0: abort on stop |
| cc_enable | input | 1 | Enables the capture-complete strobe |
| col_lo | input | CW | First window column |
| col_hi | input | CW | Last window column |
| row_lo | input | RW | First window row |
| row_hi | input | RW | Last window row |
| integ_time | input | TW | Minimum frame period in cycles |
| pix_valid | output | 1 | Pixel slot strobe |
| pix_col | output | CW | Column of current pixel |
| pix_row | output | RW | Row of current pixel |
| eor_n | output | 1 | End of row, active low |
| eof_n | output | 1 | End of frame, active low |
| irq_cc_n | output | 1 | Capture complete, active low |
| run_flag | output | 1 | Capture active |

## Verification
The hardest situations to reach are the collisions: a stop request landing on the exact last pixel of a frame, on a gap cycle, or on the first pixel after a back-to-back restart, and window or integration values changing in the same cycle a new frame latches them. The stimulus runs long random stretches with tiny windows (down to one pixel) and integration times straddling the pixel count, toggling `run` and the policy bits and rewriting the bounds every cycle, so these coincidences recur many times; directed phases first pin down each mode in isolation.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_SCAN  = 2'd1,
        FS_GAP   = 2'd2,
        FS_ABORT = 2'd3
    } frs_state_e;

    typedef struct packed {
        logic row_end;
        logic frame_end;
        logic capture_done;
    } frs_strobe_t;

    // Another frame follows only while both the mode and the request stay up.
    function automatic logic frs_keep_going(input logic cont, input logic req);
        return cont & req;
    endfunction

endpackage

// File: rtl/frs_scan.sv
module frs_scan #(
    parameter int CW = 8,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  logic [CW-1:0] col_lo,
    input  logic [CW-1:0] col_hi,
    input  logic [RW-1:0] row_lo,
    input  logic [RW-1:0] row_hi,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row,
    output logic          row_done,
    output logic          frame_done
);
    logic [CW-1:0] c_lo_q, c_hi_q;
    logic [RW-1:0] r_lo_q, r_hi_q;

    assign row_done   = (col == c_hi_q);
    assign frame_done = row_done && (row == r_hi_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            c_lo_q <= '0;
            c_hi_q <= '0;
            r_lo_q <= '0;
            r_hi_q <= '0;
            col    <= '0;
            row    <= '0;
        end else if (load) begin
            c_lo_q <= col_lo;
            c_hi_q <= col_hi;
            r_lo_q <= row_lo;
            r_hi_q <= row_hi;
            col    <= col_lo;
            row    <= row_lo;
        end else if (adv) begin
            if (frame_done) begin
                col <= c_lo_q;
                row <= r_lo_q;
            end else if (row_done) begin
                col <= c_lo_q;
                row <= row + RW'(1);
            end else begin
                col <= col + CW'(1);
            end
        end
    end

    // Coordinates stay inside the latched window while scanning.
    assert_coord_in_window_R1: assert property (@(posedge clk) disable iff (rst)
        adv |-> (col >= c_lo_q && col <= c_hi_q && row >= r_lo_q && row <= r_hi_q));

endmodule

// File: rtl/frs_period.sv
module frs_period #(
    parameter int TW = 16,
    parameter int PW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          count,
    input  logic          in_gap,
    input  logic [TW-1:0] integ_in,
    output logic          gap_needed,
    output logic          gap_done
);
    logic [PW-1:0] elapsed;
    logic [TW-1:0] integ_q;
    logic [PW-1:0] integ_w;
    logic [PW-1:0] next_elapsed;

    assign integ_w      = PW'(integ_q);
    assign next_elapsed = elapsed + PW'(1);
    assign gap_needed   = integ_w > next_elapsed;
    assign gap_done     = next_elapsed >= integ_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
            integ_q <= '0;
        end else if (clear) begin
            elapsed <= '0;
            integ_q <= integ_in;
        end else if (count) begin
            elapsed <= next_elapsed;
        end
    end

    // Gap cycles only occur while the frame period is still short of integration.
    assert_gap_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        in_gap |-> (elapsed < integ_w));

endmodule

// File: rtl/frame_readout_seq.sv
module frame_readout_seq #(
    parameter int CW = 8,
    parameter int RW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          cont_mode,
    input  logic          stop_at_end,
    input  logic          cc_enable,
    input  logic [CW-1:0] col_lo,
    input  logic [CW-1:0] col_hi,
    input  logic [RW-1:0] row_lo,
    input  logic [RW-1:0] row_hi,
    input  logic [TW-1:0] integ_time,
    output logic          pix_valid,
    output logic [CW-1:0] pix_col,
    output logic [RW-1:0] pix_row,
    output logic          eor_n,
    output logic          eof_n,
    output logic          irq_cc_n,
    output logic          run_flag
);
    import frs_pkg::*;

    localparam int PW = ((TW > CW + RW) ? TW : CW + RW) + 1;

    frs_state_e  state, state_nx;
    logic        run_q;
    logic        load;
    logic        scanning, in_gap, aborting;
    logic        row_done, frame_done;
    logic        gap_needed, gap_done;
    logic        keep_going;
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    frs_strobe_t strobe;

    assign scanning   = (state == FS_SCAN);
    assign in_gap     = (state == FS_GAP);
    assign aborting   = (state == FS_ABORT);
    assign keep_going = frs_keep_going(cont_mode, run);

    frs_scan #(.CW(CW), .RW(RW)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .adv        (scanning),
        .col_lo     (col_lo),
        .col_hi     (col_hi),
        .row_lo     (row_lo),
        .row_hi     (row_hi),
        .col        (col),
        .row        (row),
        .row_done   (row_done),
        .frame_done (frame_done)
    );

    frs_period #(.TW(TW), .PW(PW)) u_period (
        .clk        (clk),
        .rst        (rst),
        .clear      (load),
        .count      (scanning | in_gap),
        .in_gap     (in_gap),
        .integ_in   (integ_time),
        .gap_needed (gap_needed),
        .gap_done   (gap_done)
    );

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            FS_IDLE: begin
                if (run && !run_q) begin
                    load     = 1'b1;
                    state_nx = FS_SCAN;
                end
            end
            FS_SCAN: begin
                if (!run && !stop_at_end) begin
                    state_nx = FS_ABORT;
                end else if (frame_done) begin
                    if (keep_going) begin
                        if (gap_needed) begin
                            state_nx = FS_GAP;
                        end else begin
                            load     = 1'b1;
                            state_nx = FS_SCAN;
                        end
                    end else begin
                        state_nx = FS_IDLE;
                    end
                end
            end
            FS_GAP: begin
                if (!run) begin
                    state_nx = FS_IDLE;
                end else if (gap_done) begin
                    load     = 1'b1;
                    state_nx = FS_SCAN;
                end
            end
            FS_ABORT: state_nx = FS_IDLE;
            default:  state_nx = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
            run_q <= 1'b0;
        end else begin
            state <= state_nx;
            run_q <= run;
        end
    end

    always_comb begin
        strobe.row_end      = (scanning && row_done) || aborting;
        strobe.frame_end    = (scanning && frame_done) || aborting;
        strobe.capture_done = cc_enable &&
                              ((scanning && frame_done && !keep_going) || aborting);
    end

    assign pix_valid = scanning;
    assign pix_col   = scanning ? col : '0;
    assign pix_row   = scanning ? row : '0;
    assign eor_n     = ~strobe.row_end;
    assign eof_n     = ~strobe.frame_end;
    assign irq_cc_n  = ~strobe.capture_done;
    assign run_flag  = (state != FS_IDLE);

    assert_eof_with_eor_R2: assert property (@(posedge clk) disable iff (rst)
        !eof_n |-> !eor_n);

    assert_cc_with_eof_R5: assert property (@(posedge clk) disable iff (rst)
        !irq_cc_n |-> !eof_n);

    assert_start_on_request_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(run_flag) |-> $past(run));

    assert_abort_then_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!eor_n && !pix_valid) |=> !run_flag);

endmodule

// File: tb/test_frame_readout_seq.sv
module test_frame_readout_seq;
    localparam int CW = 8;
    localparam int RW = 8;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0, cont_mode = 1'b0, stop_at_end = 1'b0, cc_enable = 1'b0;
    logic [CW-1:0] col_lo = '0, col_hi = '0;
    logic [RW-1:0] row_lo = '0, row_hi = '0;
    logic [TW-1:0] integ_time = '0;
    logic          pix_valid, eor_n, eof_n, irq_cc_n, run_flag;
    logic [CW-1:0] pix_col;
    logic [RW-1:0] pix_row;

    always #2.5 clk = ~clk;

    frame_readout_seq #(.CW(CW), .RW(RW), .TW(TW)) i_frame_readout_seq (
        .clk(clk), .rst(rst), .run(run), .cont_mode(cont_mode),
        .stop_at_end(stop_at_end), .cc_enable(cc_enable),
        .col_lo(col_lo), .col_hi(col_hi), .row_lo(row_lo), .row_hi(row_hi),
        .integ_time(integ_time), .pix_valid(pix_valid), .pix_col(pix_col),
        .pix_row(pix_row), .eor_n(eor_n), .eof_n(eof_n), .irq_cc_n(irq_cc_n),
        .run_flag(run_flag)
    );

    int    n_chk = 0, n_bad = 0;
    bit    done = 0;
    string phase = "R11";

    // Reference model: 0 idle, 1 reading, 2 gap, 3 abort.
    int ms = 0, mcol = 0, mrow = 0, wcs = 0, wce = 0, wrs = 0, wre = 0;
    int m_integ = 0, gap_left = 0, mprev_run = 0;

    task automatic chk(string sig, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", phase, sig, act, exp);
        end
    endtask

    function automatic int area();
        return (wce - wcs + 1) * (wre - wrs + 1);
    endfunction

    task automatic m_load();
        wcs = col_lo; wce = col_hi; wrs = row_lo; wre = row_hi;
        m_integ = integ_time;
        mcol = wcs; mrow = wrs;
    endtask

    task automatic step_check();
        bit last_col, last, go;
        last_col = (ms == 1) && (mcol == wce);
        last     = last_col && (mrow == wre);
        go       = cont_mode && run;
        chk("pix_valid", pix_valid, ms == 1);
        chk("pix_col", pix_col, ms == 1 ? mcol : 0);
        chk("pix_row", pix_row, ms == 1 ? mrow : 0);
        chk("eor_n", eor_n, !(last_col || ms == 3));
        chk("eof_n", eof_n, !(last || ms == 3));
        chk("irq_cc_n", irq_cc_n, !(cc_enable && ((last && !go) || ms == 3)));
        chk("run_flag", run_flag, ms != 0);
        if (rst) begin
            ms = 0; mprev_run = 0; mcol = 0; mrow = 0;
            return;
        end
        case (ms)
            0: if (run && !mprev_run) begin m_load(); ms = 1; end
            1: begin
                if (!run && !stop_at_end) ms = 3;
                else if (last) begin
                    if (go) begin
                        if (m_integ > area()) begin
                            gap_left = m_integ - area(); ms = 2;
                        end else m_load();
                    end else ms = 0;
                end else if (last_col) begin
                    mcol = wcs; mrow++;
                end else mcol++;
            end
            2: begin
                if (!run) ms = 0;
                else begin
                    gap_left--;
                    if (gap_left == 0) begin m_load(); ms = 1; end
                end
            end
            default: ms = 0;
        endcase
        mprev_run = run;
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_check();
            @(posedge clk);
            #0.5;
        end
    endtask

    task automatic set_win(int cs, int w, int rs, int h);
        col_lo = CW'(cs); col_hi = CW'(cs + w - 1);
        row_lo = RW'(rs); row_hi = RW'(rs + h - 1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        // R11: reset state
        cyc(3);
        rst = 1'b0;
        cyc(2);

        // R4 + R5: single frame 3x2 with capture complete, run held high
        phase = "R4";
        set_win(2, 3, 5, 2); cc_enable = 1; integ_time = 100;
        run = 1; cyc(20);
        run = 0; cyc(2);

        // R6: continuous, integration shorter than a frame
        phase = "R6";
        cont_mode = 1; stop_at_end = 1; integ_time = 3; set_win(0, 2, 0, 2);
        run = 1; cyc(40);
        // R8: finish policy, run dropped mid-frame
        phase = "R8";
        run = 0; cyc(15);

        // R7: continuous with a gap (area 6, integ 11 -> 5 gap cycles)
        phase = "R7";
        set_win(4, 3, 1, 2); integ_time = 11;
        run = 1; cyc(45);
        phase = "R8";
        run = 0; cyc(15);   // may land in gap or frame

        // R9: abort policy with capture complete
        phase = "R9";
        stop_at_end = 0; integ_time = 0; set_win(1, 4, 1, 4);
        run = 1; cyc(7);
        run = 0; cyc(5);
        // R5: abort with capture complete disabled
        phase = "R5";
        cc_enable = 0; run = 1; cyc(3); run = 0; cyc(4);

        // R10: window and integration rewritten every cycle mid-frame
        phase = "R10";
        stop_at_end = 1; cc_enable = 1;
        set_win(3, 4, 3, 3); run = 1; cyc(1);
        for (int i = 0; i < 60; i++) begin
            set_win($urandom_range(0, 20), $urandom_range(1, 5),
                    $urandom_range(0, 20), $urandom_range(1, 5));
            integ_time = TW'($urandom_range(0, 30));
            cyc(1);
        end
        run = 0; cyc(40);

        // R11: reset in the middle of a frame
        phase = "R11";
        run = 1; cyc(4);
        rst = 1; cyc(2);
        rst = 0; run = 0; cyc(2);

        // R1 / R2: random mix, including 1x1 windows
        phase = "R1";
        for (int i = 0; i < 5000; i++) begin
            if ($urandom_range(0, 29) == 0) run = ~run;
            if ($urandom_range(0, 9) == 0) cont_mode = 1'($urandom);
            if ($urandom_range(0, 9) == 0) stop_at_end = 1'($urandom);
            if ($urandom_range(0, 9) == 0) cc_enable = 1'($urandom);
            set_win($urandom_range(0, 200), $urandom_range(1, 5),
                    $urandom_range(0, 200), $urandom_range(1, 5));
            integ_time = TW'($urandom_range(0, 40));
            if (i == 2500) phase = "R2";
            cyc(1);
        end
        summary();
    end
endmodule